// File: doc/BRIEF.md
# I2C Master Byte Transfer Sequencer

This block steps an I2C master transfer from a 16-bit control word. Software programs a byte count and a 7-bit slave address, loads outgoing bytes into a four-entry packing buffer, then writes the control word with the enable and start bits set. The sequencer asks a byte-level bus engine for a start condition, then moves one byte per send or receive handshake between the buffer and the engine. When the work is done it ends with a stop condition or leaves the bus held for a repeated start.

Two modes are offered. In counted mode a working counter, reloaded from the programmed count, limits the transfer; reaching zero clears the master bit and posts an access-ready event. In repeat mode the count plays no part, bytes flow for as long as the buffer allows, and a stop request ends the transfer. The sequencer stalls, without losing its place, when the transmit buffer runs dry or the receive buffer fills. It raises transmit-ready and receive-ready levels and one-cycle access-ready and not-acknowledged pulses toward a status unit.

Top module: `i2cs_xfer_seq`

## Requirements
- R1: A control write is stored ANDed with 0xCF87 (start bit 0, stop bit 1, repeat bit 2, direction bit 9 with 1 = transmit, master bit 10, enable bit 15); when bit 15 is clear no start is requested.
- R2: A control write with bits 15 and 0 both set while idle reloads the working count from the programmed count and requests a start to the slave address with the read flag equal to the inverse of bit 9; bit 0 reads back clear once the start completes.
- R3: A refused start gives a one-cycle NACK pulse, clears bits 0, 1 and 10, and moves no bytes and issues no stop.
- R4: In counted transmit, bytes are sent oldest first, one send handshake each, the count drops by one per acknowledged byte, and with bytes still owed and the buffer empty the sequencer stalls with transmit-ready high.
- R5: In counted receive, bytes are fetched while the count is non-zero and the buffer holds fewer than 4 bytes; receive-ready is high whenever the direction is receive and the buffer is not empty.
- R6: When the count is zero, a one-cycle access-ready pulse is given with bit 10 cleared; if bit 1 is set a stop is then requested, and after it completes bit 1 reads clear and the count is reloaded.
- R7: In repeat mode the count is neither tested nor changed and no access-ready pulse is given; bytes move until bit 1 is set, which ends the transfer with a stop and clears bit 10.
- R8: A byte that is not acknowledged gives a one-cycle NACK pulse, clears bits 1 and 10, does not change the count, and no further byte or stop is requested.
- R9: The buffer is first-in first-out with 4 entries; a push to a full buffer and a pop from an empty one are ignored.
- R10: At most one of the four engine requests is active at a time, and a send request is held until its done.
- R11: While a transfer is active, a control write changes only bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 16 | Control write value |
| ctrl_q | output | 16 | Current control word |
| cnt_cfg | input | 16 | Programmed byte count |
| cnt_cur | output | 16 | Working byte count |
| slave_addr | input | 7 | Target slave address |
| buf_push | input | 1 | Host pushes a byte into the buffer |
| buf_wdata | input | 8 | Byte pushed by the host |
| buf_pop | input | 1 | Host removes the oldest byte |
| buf_rdata | output | 8 | Oldest byte in the buffer |
| buf_level | output | 3 | Bytes held in the buffer |
| eng_start_req | output | 1 | Start condition request |
| eng_start_rnw | output | 1 | Read flag for the start |
| eng_addr | output | 7 | Address for the start |
| eng_start_done | input | 1 | Start finished |
| eng_start_nack | input | 1 | Start refused, valid with done |
| eng_send_req | output | 1 | Byte send request |
| eng_send_data | output | 8 | Byte to send |
| eng_send_done | input | 1 | Send finished |
| eng_send_ack | input | 1 | Byte acknowledged, valid with done |
| eng_recv_req | output | 1 | Byte receive request |
| eng_recv_done | input | 1 | Receive finished |
| eng_recv_data | input | 8 | Received byte, valid with done |
| eng_stop_req | output | 1 | Stop condition request |
| eng_stop_done | input | 1 | Stop finished |
| evt_xrdy | output | 1 | Transmit data wanted |
| evt_rrdy | output | 1 | Receive data available |
| evt_ardy | output | 1 | Access-ready pulse |
| evt_nack | output | 1 | Not-acknowledged pulse |
| busy | output | 1 | Transfer in progress |

## Verification
A start request appears one cycle after the control write, and every byte costs three cycles: the request, the engine's done one cycle later, and one decision cycle, with the working count and buffer level moving on the edge that samples done. Access-ready and NACK pulses last exactly one cycle and come one edge after the deciding state, so the bench counts them with a clocked monitor rather than sampling at a guessed cycle. Stall checks are taken after a settling wait far longer than the bytes need, and end-of-transfer checks after busy drops, always sampled on the falling edge.

// File: rtl/i2cs_pkg.sv
// Shared definitions for the I2C master byte sequencer: control bit
// positions, the write mask and the sequencer state type.
package i2cs_pkg;
    localparam int CTRL_W    = 16;
    localparam int B_STT     = 0;
    localparam int B_STP     = 1;
    localparam int B_RM      = 2;
    localparam int B_TRX     = 9;
    localparam int B_MST     = 10;
    localparam int B_EN      = 15;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hCF87;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_RUN,
        ST_SEND,
        ST_RECV,
        ST_STOP
    } seq_state_t;
endpackage

// File: rtl/i2cs_pack_buf.sv
// Byte packing buffer: a small first-in first-out store shared by both
// directions. Assumes DEPTH is a power of two. Pushes when full and pops
// when empty are dropped.
module i2cs_pack_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/i2cs_byte_cnt.sv
// Working byte counter: loads the programmed count, steps down once per
// completed byte and never wraps below zero.
module i2cs_byte_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] value,
    output logic             zero
);
    assign zero = (value == '0);

    // Load has priority over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)             value <= '0;
        else if (load)          value <= load_val;
        else if (dec && !zero)  value <= value - 1'b1;
    end
endmodule

// File: rtl/i2cs_seq_ctrl.sv
// Transfer state machine and control word. Issues one engine request at a
// time and waits for its done. Assumes done and its qualifiers are valid in
// the same cycle and that the engine drops done once the request falls.
module i2cs_seq_ctrl
    import i2cs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              cnt_zero,
    output logic              cnt_load,
    output logic              cnt_dec,
    input  logic              buf_empty,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_head,
    output logic              buf_pop_seq,
    output logic              buf_push_seq,
    output logic              start_req,
    input  logic              start_done,
    input  logic              start_nack,
    output logic              send_req,
    output logic [DATA_W-1:0] send_data,
    input  logic              send_done,
    input  logic              send_ack,
    output logic              recv_req,
    input  logic              recv_done,
    output logic              stop_req,
    input  logic              stop_done,
    output logic              xrdy,
    output logic              ardy,
    output logic              nack,
    output logic              busy
);
    seq_state_t        st, st_n;
    logic [CTRL_W-1:0] ctrl_n;
    logic [DATA_W-1:0] byte_n;
    logic              ardy_n, nack_n, tx, rm, active;

    assign tx        = ctrl_q[B_TRX];
    assign rm        = ctrl_q[B_RM];
    assign start_req = (st == ST_START);
    assign send_req  = (st == ST_SEND);
    assign recv_req  = (st == ST_RECV);
    assign stop_req  = (st == ST_STOP);
    assign busy      = (st != ST_IDLE);
    assign active    = (st == ST_RUN) || (st == ST_SEND) || (st == ST_RECV);
    assign xrdy      = active && tx && (rm || !cnt_zero) && !buf_full;

    // Next-state, control update and per-byte actions.
    always_comb begin
        st_n         = st;
        ctrl_n       = ctrl_q;
        byte_n       = send_data;
        ardy_n       = 1'b0;
        nack_n       = 1'b0;
        cnt_load     = 1'b0;
        cnt_dec      = 1'b0;
        buf_pop_seq  = 1'b0;
        buf_push_seq = 1'b0;
        if (ctrl_wr) begin
            if (st == ST_IDLE) ctrl_n = ctrl_wdata & CTRL_MASK;
            else               ctrl_n[B_STP] = ctrl_wdata[B_STP];
        end
        case (st)
            ST_IDLE: begin
                if (ctrl_wr && ctrl_wdata[B_EN] && ctrl_wdata[B_STT]) begin
                    st_n     = ST_START;
                    cnt_load = 1'b1;
                end
            end
            ST_START: begin
                if (start_done) begin
                    ctrl_n[B_STT] = 1'b0;
                    if (start_nack) begin
                        nack_n        = 1'b1;
                        ctrl_n[B_STP] = 1'b0;
                        ctrl_n[B_MST] = 1'b0;
                        st_n          = ST_IDLE;
                    end else begin
                        st_n = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (rm && ctrl_n[B_STP]) begin
                    ctrl_n[B_MST] = 1'b0;
                    st_n          = ST_STOP;
                end else if (!rm && cnt_zero) begin
                    ardy_n        = 1'b1;
                    ctrl_n[B_MST] = 1'b0;
                    st_n          = ctrl_n[B_STP] ? ST_STOP : ST_IDLE;
                end else if (tx && !buf_empty) begin
                    buf_pop_seq = 1'b1;
                    byte_n      = buf_head;
                    st_n        = ST_SEND;
                end else if (!tx && !buf_full) begin
                    st_n = ST_RECV;
                end
            end
            ST_SEND: begin
                if (send_done) begin
                    if (send_ack) begin
                        cnt_dec = !rm;
                        st_n    = ST_RUN;
                    end else begin
                        nack_n        = 1'b1;
                        ctrl_n[B_STP] = 1'b0;
                        ctrl_n[B_MST] = 1'b0;
                        st_n          = ST_IDLE;
                    end
                end
            end
            ST_RECV: begin
                if (recv_done) begin
                    buf_push_seq = 1'b1;
                    cnt_dec      = !rm;
                    st_n         = ST_RUN;
                end
            end
            ST_STOP: begin
                if (stop_done) begin
                    ctrl_n[B_STP] = 1'b0;
                    cnt_load      = 1'b1;
                    st_n          = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State, control word, outgoing byte and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ctrl_q    <= '0;
            send_data <= '0;
            ardy      <= 1'b0;
            nack      <= 1'b0;
        end else begin
            st        <= st_n;
            ctrl_q    <= ctrl_n;
            send_data <= byte_n;
            ardy      <= ardy_n;
            nack      <= nack_n;
        end
    end
endmodule

// File: rtl/i2cs_xfer_seq.sv
// Top of the I2C master byte sequencer: joins the state machine, the
// working counter and the packing buffer. Host pushes are dropped while the
// sequencer stores a received byte in the same cycle.
module i2cs_xfer_seq
    import i2cs_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 7,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [15:0]       ctrl_wdata,
    output logic [15:0]       ctrl_q,
    input  logic [CNT_W-1:0]  cnt_cfg,
    output logic [CNT_W-1:0]  cnt_cur,
    input  logic [ADDR_W-1:0] slave_addr,
    input  logic              buf_push,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_pop,
    output logic [DATA_W-1:0] buf_rdata,
    output logic [LVL_W-1:0]  buf_level,
    output logic              eng_start_req,
    output logic              eng_start_rnw,
    output logic [ADDR_W-1:0] eng_addr,
    input  logic              eng_start_done,
    input  logic              eng_start_nack,
    output logic              eng_send_req,
    output logic [DATA_W-1:0] eng_send_data,
    input  logic              eng_send_done,
    input  logic              eng_send_ack,
    output logic              eng_recv_req,
    input  logic              eng_recv_done,
    input  logic [DATA_W-1:0] eng_recv_data,
    output logic              eng_stop_req,
    input  logic              eng_stop_done,
    output logic              evt_xrdy,
    output logic              evt_rrdy,
    output logic              evt_ardy,
    output logic              evt_nack,
    output logic              busy
);
    logic cnt_zero, cnt_load, cnt_dec;
    logic b_empty, b_full, pop_seq, push_seq;

    assign eng_start_rnw = !ctrl_q[B_TRX];
    assign eng_addr      = slave_addr;
    assign evt_rrdy      = !ctrl_q[B_TRX] && !b_empty;

    i2cs_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_dec(cnt_dec),
        .buf_empty(b_empty), .buf_full(b_full), .buf_head(buf_rdata),
        .buf_pop_seq(pop_seq), .buf_push_seq(push_seq),
        .start_req(eng_start_req), .start_done(eng_start_done),
        .start_nack(eng_start_nack),
        .send_req(eng_send_req), .send_data(eng_send_data),
        .send_done(eng_send_done), .send_ack(eng_send_ack),
        .recv_req(eng_recv_req), .recv_done(eng_recv_done),
        .stop_req(eng_stop_req), .stop_done(eng_stop_done),
        .xrdy(evt_xrdy), .ardy(evt_ardy), .nack(evt_nack), .busy(busy)
    );

    i2cs_byte_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(cnt_load), .load_val(cnt_cfg), .dec(cnt_dec),
        .value(cnt_cur), .zero(cnt_zero)
    );

    i2cs_pack_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push(push_seq || buf_push),
        .wdata(push_seq ? eng_recv_data : buf_wdata),
        .pop(pop_seq || buf_pop),
        .head(buf_rdata), .level(buf_level),
        .empty(b_empty), .full(b_full)
    );
endmodule

// File: rtl/i2cs_xfer_seq_chk.sv
// Property checker for the sequencer, attached to every instance by bind.
module i2cs_xfer_seq_chk #(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      ctrl_q,
    input logic [CNT_W-1:0] cnt_cur,
    input logic [LVL_W-1:0] buf_level,
    input logic             eng_start_req,
    input logic             eng_send_req,
    input logic             eng_send_done,
    input logic             eng_recv_req,
    input logic             eng_stop_req,
    input logic             evt_ardy,
    input logic             evt_nack
);
    assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_start_req, eng_send_req, eng_recv_req, eng_stop_req}));

    assert_send_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_send_req && !eng_send_done) |=> eng_send_req);

    assert_ardy_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ardy |-> (!ctrl_q[10] && cnt_cur == '0));

    assert_stt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_start_req) |-> !ctrl_q[0]);

    assert_nack_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_nack |=> (!eng_send_req && !eng_recv_req && !eng_stop_req));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_level <= LVL_W'(DEPTH));
endmodule

bind i2cs_xfer_seq i2cs_xfer_seq_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .cnt_cur(cnt_cur),
    .buf_level(buf_level), .eng_start_req(eng_start_req),
    .eng_send_req(eng_send_req), .eng_send_done(eng_send_done),
    .eng_recv_req(eng_recv_req), .eng_stop_req(eng_stop_req),
    .evt_ardy(evt_ardy), .evt_nack(evt_nack)
);

// File: tb/tb_i2cs_xfer_seq.sv
`timescale 1ns/1ps
module tb_i2cs_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic [15:0] ctrl_q;
    logic [15:0] cnt_cfg = '0;
    logic [15:0] cnt_cur;
    logic [6:0]  slave_addr = 7'h2A;
    logic        buf_push = 1'b0;
    logic [7:0]  buf_wdata = '0;
    logic        buf_pop = 1'b0;
    logic [7:0]  buf_rdata;
    logic [2:0]  buf_level;
    logic        st_req, st_rnw, st_done = 1'b0, st_nack = 1'b0;
    logic [6:0]  e_addr;
    logic        sd_req, sd_done = 1'b0, sd_ack = 1'b0;
    logic [7:0]  sd_data;
    logic        rv_req, rv_done = 1'b0;
    logic [7:0]  rv_data = '0;
    logic        sp_req, sp_done = 1'b0;
    logic        xrdy, rrdy, ardy, nack, busy;

    int   checks = 0, fails = 0;
    int   sent_n = 0, recv_n = 0, stop_n = 0, start_n = 0, ardy_n = 0, nack_n = 0;
    logic [7:0] sent_q [64];
    logic       cap_rnw = 1'b0;
    logic [6:0] cap_addr = '0;
    logic       refuse_start = 1'b0;
    int         nack_at = -1;

    always #10 clk = ~clk;

    i2cs_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .cnt_cfg(cnt_cfg), .cnt_cur(cnt_cur),
        .slave_addr(slave_addr), .buf_push(buf_push), .buf_wdata(buf_wdata),
        .buf_pop(buf_pop), .buf_rdata(buf_rdata), .buf_level(buf_level),
        .eng_start_req(st_req), .eng_start_rnw(st_rnw), .eng_addr(e_addr),
        .eng_start_done(st_done), .eng_start_nack(st_nack),
        .eng_send_req(sd_req), .eng_send_data(sd_data),
        .eng_send_done(sd_done), .eng_send_ack(sd_ack),
        .eng_recv_req(rv_req), .eng_recv_done(rv_done), .eng_recv_data(rv_data),
        .eng_stop_req(sp_req), .eng_stop_done(sp_done),
        .evt_xrdy(xrdy), .evt_rrdy(rrdy), .evt_ardy(ardy), .evt_nack(nack),
        .busy(busy)
    );

    // Bus engine model: done one cycle after each request, then drops.
    always @(posedge clk) begin
        st_done <= st_req && !st_done;
        sd_done <= sd_req && !sd_done;
        rv_done <= rv_req && !rv_done;
        sp_done <= sp_req && !sp_done;
        if (st_req && !st_done) begin
            st_nack  <= refuse_start;
            cap_rnw  <= st_rnw;
            cap_addr <= e_addr;
            start_n  <= start_n + 1;
        end
        if (sd_req && !sd_done) begin
            sent_q[sent_n % 64] <= sd_data;
            sd_ack <= (sent_n + 1 != nack_at);
            sent_n <= sent_n + 1;
        end
        if (rv_req && !rv_done) begin
            rv_data <= 8'hA0 + 8'(recv_n);
            recv_n  <= recv_n + 1;
        end
        if (sp_req && !sp_done) stop_n <= stop_n + 1;
        if (ardy) ardy_n <= ardy_n + 1;
        if (nack) nack_n <= nack_n + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); buf_push = 1'b1; buf_wdata = b;
        @(negedge clk); buf_push = 1'b0;
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, int'(buf_rdata), int'(exp));
        buf_pop = 1'b1;
        @(negedge clk); buf_pop = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset ctrl", int'(ctrl_q), 0);
        chk("R4 reset count", int'(cnt_cur), 0);
        chk("R9 reset level", int'(buf_level), 0);
        chk("R10 reset reqs", int'({st_req, sd_req, rv_req, sp_req, busy}), 0);
    endtask

    task automatic t_mask();
        int s0 = start_n;
        wr_ctrl(16'h7FFF);
        settle(4);
        chk("R1 masked store", int'(ctrl_q), 16'h4F87);
        chk("R1 no start without enable", start_n - s0, 0);
        chk("R1 idle", int'(busy), 0);
        wr_ctrl(16'h0000);
    endtask

    task automatic t_tx_normal();
        int s0 = sent_n, a0 = ardy_n, p0 = stop_n;
        cnt_cfg = 16'd3;
        push(8'h11); push(8'h22);
        wr_ctrl(16'h8603);
        settle(20);
        chk("R2 write flag", int'(cap_rnw), 0);
        chk("R2 address", int'(cap_addr), 16'h2A);
        chk("R4 sent before stall", sent_n - s0, 2);
        chk("R4 count after two", int'(cnt_cur), 1);
        chk("R4 stall xrdy", int'(xrdy), 1);
        chk("R2 stt cleared", int'(ctrl_q[0]), 0);
        push(8'h33);
        wait_idle();
        chk("R4 sent total", sent_n - s0, 3);
        chk("R4 order 0", int'(sent_q[s0 % 64]), 16'h11);
        chk("R4 order 1", int'(sent_q[(s0 + 1) % 64]), 16'h22);
        chk("R4 order 2", int'(sent_q[(s0 + 2) % 64]), 16'h33);
        chk("R6 ardy pulse", ardy_n - a0, 1);
        chk("R6 stop issued", stop_n - p0, 1);
        chk("R6 stp mst clear", int'({ctrl_q[10], ctrl_q[1]}), 0);
        chk("R6 count reload", int'(cnt_cur), 3);
        chk("R6 xrdy low", int'(xrdy), 0);
    endtask

    task automatic t_rx_normal();
        int r0 = recv_n, a0 = ardy_n, p0 = stop_n;
        cnt_cfg = 16'd6;
        wr_ctrl(16'h8401);
        settle(30);
        chk("R2 read flag", int'(cap_rnw), 1);
        chk("R5 fetched until full", recv_n - r0, 4);
        chk("R5 level full", int'(buf_level), 4);
        chk("R5 rrdy", int'(rrdy), 1);
        chk("R5 count", int'(cnt_cur), 2);
        for (int i = 0; i < 4; i++) pop_chk("R5 data", 8'hA0 + 8'(r0 + i));
        wait_idle();
        for (int i = 4; i < 6; i++) pop_chk("R5 data tail", 8'hA0 + 8'(r0 + i));
        chk("R5 total fetched", recv_n - r0, 6);
        chk("R5 rrdy low when empty", int'(rrdy), 0);
        chk("R6 ardy rx", ardy_n - a0, 1);
        chk("R6 no stop without stp", stop_n - p0, 0);
        chk("R6 count zero kept", int'(cnt_cur), 0);
        chk("R6 mst clear rx", int'(ctrl_q[10]), 0);
    endtask

    task automatic t_start_nack();
        int n0 = nack_n, s0 = sent_n, p0 = stop_n;
        cnt_cfg = 16'd2;
        refuse_start = 1'b1;
        wr_ctrl(16'h8603);
        wait_idle();
        refuse_start = 1'b0;
        chk("R3 nack pulse", nack_n - n0, 1);
        chk("R3 no bytes", sent_n - s0, 0);
        chk("R3 no stop", stop_n - p0, 0);
        chk("R3 bits cleared", int'({ctrl_q[10], ctrl_q[1], ctrl_q[0]}), 0);
    endtask

    task automatic t_data_nack();
        int n0 = nack_n, s0 = sent_n, p0 = stop_n;
        cnt_cfg = 16'd4;
        push(8'h51); push(8'h52); push(8'h53); push(8'h54);
        nack_at = s0 + 2;
        wr_ctrl(16'h8603);
        wait_idle();
        nack_at = -1;
        chk("R8 bytes tried", sent_n - s0, 2);
        chk("R8 nack pulse", nack_n - n0, 1);
        chk("R8 no stop", stop_n - p0, 0);
        chk("R8 count", int'(cnt_cur), 3);
        chk("R8 stp mst clear", int'({ctrl_q[10], ctrl_q[1]}), 0);
        pop_chk("R8 left in buffer", 8'h53);
        pop_chk("R8 left in buffer", 8'h54);
    endtask

    task automatic t_repeat();
        int s0 = sent_n, a0 = ardy_n, p0 = stop_n;
        cnt_cfg = 16'd5;
        push(8'h61); push(8'h62);
        wr_ctrl(16'h8605);
        settle(20);
        chk("R7 sent", sent_n - s0, 2);
        chk("R7 count untouched", int'(cnt_cur), 5);
        chk("R7 xrdy while waiting", int'(xrdy), 1);
        chk("R7 still busy", int'(busy), 1);
        wr_ctrl(16'h0002);
        wait_idle();
        chk("R7 stop issued", stop_n - p0, 1);
        chk("R7 no ardy", ardy_n - a0, 0);
        chk("R7 mst clear", int'(ctrl_q[10]), 0);
        chk("R11 enable kept", int'(ctrl_q[15]), 1);
        chk("R11 repeat kept", int'(ctrl_q[2]), 1);
    endtask

    task automatic t_buf();
        wr_ctrl(16'h0000);
        for (int i = 0; i < 5; i++) push(8'h70 + 8'(i));
        chk("R9 capacity", int'(buf_level), 4);
        for (int i = 0; i < 4; i++) pop_chk("R9 order", 8'h70 + 8'(i));
        @(negedge clk); buf_pop = 1'b1;
        @(negedge clk); buf_pop = 1'b0;
        chk("R9 pop when empty", int'(buf_level), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_tx_normal();
        t_rx_normal();
        t_start_nack();
        t_data_nack();
        t_repeat();
        t_buf();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule